// File: doc/BRIEF.md
# Desaturation Fault Protection Controller

This block supervises a power transistor on the isolated output side of a gate driver and handles a short circuit from detection to recovery. Whenever the transistor is commanded off, and for a fixed masking interval after each turn-on, it keeps the blanking-capacitor discharge switch closed. This holds the sense node low so that turn-on transients cannot be mistaken for an overcurrent. Once the mask has run out, a high flag from the external desaturation comparator latches a fault. The latched fault selects the slow soft turn-off path, holds the main driver off, and after a programmed delay pulls the active-low fault report down.

The fault stays latched until the active-low clear input is held low for a debounce interval and then returns high. A shorter low pulse leaves the latch untouched. The gate is also held off for as long as the clear input is low. The comparator flag and the clear input are asynchronous, and each passes through its own synchronizer. All delays are parameters counted in clock cycles.

Top module: `desat_guard`

## Requirements
- R1: `blank_sw` is 1 (discharge switch closed) in every cycle in which `drive_cmd` is 0 or `force_off` is 1.
- R2: After `drive_cmd` goes high while nothing forces the gate off, `blank_sw` stays 1 for exactly MASK_CYC rising clock edges and then goes to 0 while the drive stays on.
- R3: A high `desat_raw` latches a fault only if its two-flop synchronized copy is high at an edge where the drive is on, not forced off, and past its mask. A flag that is high only during the mask or during the off time has no effect.
- R4: When `desat_raw` rises while the switch is open, `soft_off_en` and `force_off` both go to 1 on the third rising edge.
- R5: `fault_n` goes to 0 exactly REPORT_CYC rising edges after `soft_off_en` rises, and stays 0 while the fault is latched.
- R6: While a fault is latched (`soft_off_en`=1), `force_off` is 1 whatever `drive_cmd` does.
- R7: If the synchronized `clr_n_raw` has been 0 for at least DEB_CYC consecutive edges, the first edge that sees it at 1 again clears the fault: `soft_off_en` and `force_off` fall to 0 and `fault_n` returns to 1.
- R8: A clear pulse shorter than DEB_CYC synchronized edges leaves the latched fault unchanged. The debounce count restarts from zero every time the clear input returns high.
- R9: While the synchronized clear input is 0, `force_off` is 1 even when no fault is latched.
- R10: While `rst_n` is 0: `blank_sw`=1, `soft_off_en`=0, `force_off`=0, `fault_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_cmd | input | 1 | Qualified gate-on command, synchronous to clk |
| desat_raw | input | 1 | Asynchronous desaturation comparator flag |
| clr_n_raw | input | 1 | Asynchronous active-low fault clear |
| blank_sw | output | 1 | 1 closes the blanking-capacitor discharge switch |
| soft_off_en | output | 1 | 1 selects the soft turn-off path |
| force_off | output | 1 | 1 holds the main gate driver off |
| fault_n | output | 1 | Active-low fault report |

## Verification
A corrupted mask count shows at the `blank_sw` port in the cycle where the switch opens. That cycle moves away from edge MASK_CYC after turn-on, or the switch reopens while the drive is off. A latch that sets or clears wrongly changes `soft_off_en` and `force_off` within one edge of the qualifying input. An error in the report or debounce counters shows only later, as a shifted `fault_n` fall after REPORT_CYC edges or as a release after a clear pulse of the wrong length. The bench therefore times these edges exactly, and it compares every output in every cycle against a cycle-level model.

// File: rtl/desat_guard_pkg.sv
package desat_guard_pkg;
  // width needed to hold the values 0..max
  function automatic int cnt_w(input int max);
    return (max < 2) ? 1 : $clog2(max + 1);
  endfunction
endpackage

// File: rtl/desat_guard_sync.sv
module desat_guard_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d;
    end else begin : g_many
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/desat_guard_cnt.sv
module desat_guard_cnt
  import desat_guard_pkg::*;
#(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic done
);
  localparam int         W   = cnt_w(MAX);
  localparam logic [W-1:0] LIM = W'(MAX);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIM);
endmodule

// File: rtl/desat_guard.sv
module desat_guard #(
  parameter int MASK_CYC    = 30,
  parameter int REPORT_CYC  = 150,
  parameter int DEB_CYC     = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_cmd,
  input  logic desat_raw,
  input  logic clr_n_raw,
  output logic blank_sw,
  output logic soft_off_en,
  output logic force_off,
  output logic fault_n
);
  logic desat_s;
  logic clr_s;
  logic eff_on;
  logic mask_done;
  logic rpt_done;
  logic deb_done;
  logic flt_q;
  logic flt_d;

  desat_guard_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_desat (
    .clk(clk), .rst_n(rst_n), .d(desat_raw), .q(desat_s));

  desat_guard_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clr (
    .clk(clk), .rst_n(rst_n), .d(clr_n_raw), .q(clr_s));

  assign force_off = flt_q | ~clr_s;
  assign eff_on    = drive_cmd & ~force_off;

  // on-time mask, restarts whenever the effective drive drops
  desat_guard_cnt #(.MAX(MASK_CYC)) u_mask (
    .clk(clk), .rst_n(rst_n), .clr(~eff_on), .done(mask_done));

  // deferral of the fault report
  desat_guard_cnt #(.MAX(REPORT_CYC)) u_report (
    .clk(clk), .rst_n(rst_n), .clr(~flt_q), .done(rpt_done));

  // low time of the clear input, restarts when it goes high
  desat_guard_cnt #(.MAX(DEB_CYC)) u_debounce (
    .clk(clk), .rst_n(rst_n), .clr(clr_s), .done(deb_done));

  always_comb begin
    if (flt_q) flt_d = ~(clr_s & deb_done);
    else       flt_d = eff_on & mask_done & desat_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= 1'b0;
    else        flt_q <= flt_d;
  end

  assign blank_sw    = ~(eff_on & mask_done);
  assign soft_off_en = flt_q;
  assign fault_n     = ~(flt_q & rpt_done);
endmodule

// File: rtl/desat_guard_chk.sv
module desat_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic drive_cmd,
  input logic clr_s,
  input logic blank_sw,
  input logic soft_off_en,
  input logic force_off,
  input logic fault_n
);
  a_r1_closed_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_cmd || force_off) |-> blank_sw);

  a_r3_fault_needs_open_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_off_en) |-> $past(!blank_sw));

  a_r5_report_only_when_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> soft_off_en);

  a_r6_latched_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off_en |-> force_off);

  a_r7_release_on_clear_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_off_en) |-> clr_s);

  a_r9_clear_low_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |-> force_off);
endmodule

bind desat_guard desat_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drive_cmd(drive_cmd), .clr_s(clr_s),
  .blank_sw(blank_sw), .soft_off_en(soft_off_en), .force_off(force_off),
  .fault_n(fault_n));

// File: tb/desat_guard_test.sv
module desat_guard_test;
  localparam int MASK = 30;
  localparam int REP  = 150;
  localparam int DEB  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drive_cmd = 1'b0;
  logic desat_raw = 1'b0;
  logic clr_n_raw = 1'b1;
  logic blank_sw, soft_off_en, force_off, fault_n;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  desat_guard #(.MASK_CYC(MASK), .REPORT_CYC(REP), .DEB_CYC(DEB), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .drive_cmd(drive_cmd), .desat_raw(desat_raw),
    .clr_n_raw(clr_n_raw), .blank_sw(blank_sw), .soft_off_en(soft_off_en),
    .force_off(force_off), .fault_n(fault_n));

  // cycle-level reference built from the requirements
  logic [1:0] m_ds, m_cs;
  int m_on, m_age, m_low;
  logic m_flt;

  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ds <= 2'b00; m_cs <= 2'b11; m_on <= 0; m_age <= 0; m_low <= 0; m_flt <= 1'b0;
    end else begin
      bit held, live, qual, freed;
      held  = m_flt || !m_cs[1];
      live  = drive_cmd && !held;
      qual  = live && (m_on == MASK) && m_ds[1];
      freed = m_flt && m_cs[1] && (m_low == DEB);
      m_on  <= live ? sat(m_on + 1, MASK) : 0;
      m_age <= m_flt ? sat(m_age + 1, REP) : 0;
      m_low <= m_cs[1] ? 0 : sat(m_low + 1, DEB);
      m_flt <= m_flt ? !freed : qual;
      m_ds  <= {m_ds[0], desat_raw};
      m_cs  <= {m_cs[0], clr_n_raw};
    end
  end

  function automatic bit exp_force();
    return m_flt || !m_cs[1];
  endfunction
  function automatic bit exp_blank();
    return !(drive_cmd && !exp_force() && (m_on == MASK));
  endfunction
  function automatic bit exp_fault_n();
    return !(m_flt && (m_age == REP));
  endfunction

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1/R2", "blank_sw", blank_sw, exp_blank());
    chk("R4", "soft_off_en", soft_off_en, m_flt);
    chk("R6/R9", "force_off", force_off, exp_force());
    chk("R5", "fault_n", fault_n, exp_fault_n());
  endtask

  task automatic step();
    @(negedge clk);
    #1 cmp_all();
  endtask

  task automatic chk_int(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic clear_pulse(input int len);
    @(negedge clk); clr_n_raw = 1'b0;
    repeat (len - 1) step();
    @(negedge clk); clr_n_raw = 1'b1;
    repeat (4) step();
  endtask

  task automatic make_fault(output int lat);
    int n;
    drive_cmd = 1'b1;
    repeat (MASK + 2) step();
    @(negedge clk); desat_raw = 1'b1;
    n = 0;
    while (!soft_off_en && n < 10) begin step(); n++; end
    lat = n;
    @(negedge clk); desat_raw = 1'b0;
  endtask

  initial begin
    int n;
    int low_left;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10", "blank_sw", blank_sw, 1'b1);
    chk("R10", "soft_off_en", soft_off_en, 1'b0);
    chk("R10", "force_off", force_off, 1'b0);
    chk("R10", "fault_n", fault_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step();

    // R2 mask length
    @(negedge clk); drive_cmd = 1'b1;
    n = 0;
    while (blank_sw && n < 100) begin step(); n++; end
    chk_int("R2", "edges until switch opens", n, MASK);
    // R1 switch closes immediately when the drive drops
    @(negedge clk); drive_cmd = 1'b0;
    #1 chk("R1", "blank_sw at drive off", blank_sw, 1'b1);
    repeat (3) step();

    // R3 flag during the mask is ignored
    @(negedge clk); drive_cmd = 1'b1; desat_raw = 1'b1;
    repeat (MASK - 4) step();
    @(negedge clk); desat_raw = 1'b0;
    repeat (10) step();
    chk("R3", "no fault from masked flag", soft_off_en, 1'b0);
    // R3 flag during off time is ignored
    @(negedge clk); drive_cmd = 1'b0; desat_raw = 1'b1;
    repeat (10) step();
    chk("R3", "no fault while off", soft_off_en, 1'b0);
    @(negedge clk); desat_raw = 1'b0;
    repeat (3) step();

    // R4 latency, R5 report delay, R6 forced off
    make_fault(n);
    chk_int("R4", "edges until soft off", n, 3);
    chk("R6", "force_off with fault", force_off, 1'b1);
    n = 1;
    while (fault_n && n < 400) begin step(); n++; end
    chk_int("R5", "edges until report", n, REP);
    @(negedge clk); drive_cmd = 1'b1;
    #1 chk("R6", "drive ignored while latched", blank_sw, 1'b1);

    // R8 short clear ignored
    clear_pulse(DEB - 1);
    chk("R8", "latch kept after short clear", soft_off_en, 1'b1);
    chk("R8", "report kept after short clear", fault_n, 1'b0);
    // R7 long clear releases
    clear_pulse(DEB + 1);
    chk("R7", "latch released", soft_off_en, 1'b0);
    chk("R7", "report released", fault_n, 1'b1);
    // R9 clear low forces off without fault
    @(negedge clk); clr_n_raw = 1'b0;
    repeat (3) step();
    chk("R9", "force_off during clear", force_off, 1'b1);
    @(negedge clk); clr_n_raw = 1'b1;
    repeat (4) step();
    // R8 restart: two short pulses back to back do not add up
    make_fault(n);
    clear_pulse(DEB - 5);
    clear_pulse(DEB - 5);
    chk("R8", "pulses do not accumulate", soft_off_en, 1'b1);
    clear_pulse(DEB + 3);
    drive_cmd = 1'b0;
    repeat (4) step();

    // random phase
    low_left = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 39) == 0) drive_cmd = ~drive_cmd;
      desat_raw = drive_cmd && ($urandom_range(0, 24) == 0);
      if (low_left > 0) begin
        low_left--;
        clr_n_raw = (low_left == 0);
      end else if ($urandom_range(0, 199) == 0) begin
        low_left = $urandom_range(1, 2 * DEB);
        clr_n_raw = 1'b0;
      end
      #1 cmp_all();
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule